// File: doc/BRIEF.md
# Stereo S/PDIF Serializer

This block turns a stream of stereo sample pairs into a biphase-mark coded S/PDIF line signal. Software programs a small register set: a run bit, a flag that marks the payload as audio or non-audio, a four-bit sampling-rate code, and a divider. The divider sets the length of one half-cell of the line code in bus clock cycles. Each 32-bit word pushed into the sample FIFO holds the left sample in its low half and the right sample in its high half. Both samples go out in one frame, left subframe first.

Every subframe has 32 slots. Slots 0 to 3 carry one of three preambles, which break the coding rule so that a receiver can lock onto them. The 16-bit sample sits left-aligned in a 24-bit field. The subframe closes with the validity, user, channel-status and parity bits. Channel status is spread over a block of frames, one bit per frame. If the FIFO is empty when a frame starts, silence is sent with the validity bit set, and a sticky flag records the event until software clears it.

Top module: `spdif_tx`

## Requirements
- R1: Each half-cell of the line code lasts exactly DIV bus clock cycles, where DIV is the divider register. Divider values 0 and 1 act as 2.
- R2: Registers are written when reg_we_i is high and read combinationally on reg_rdata_o. Address 0 is control: bit 0 run, bit 1 non-audio, bits 7:4 rate code, reset value 0x20. Address 1 is the divider, reset value CLK_HZ/(48000*128), which is 16 at the default parameters. Address 2 is status: bit 0 is the sticky underflow flag (writing 1 to bit 0 clears it) and bit 1 reads back the non-audio flag.
- R3: sample_ready_o is high while the FIFO has room. A word is taken when sample_valid_i and sample_ready_o are both high. Words leave the FIFO in order, one per frame: bits 15:0 go to the left subframe and bits 31:16 to the right subframe.
- R4: Subframe slot layout: slots 4-11 are zero, slots 12-27 carry the sample LSB first, slot 28 is validity, slot 29 (user) is zero, slot 30 is channel status, and slot 31 makes the number of ones in slots 4-31 even.
- R5: The left subframe of frame 0 of each 192-frame block uses preamble B, every other left subframe uses M, and every right subframe uses W. Written as half-cells, first half-cell first, after a low line level the patterns are B=11101000, M=11100010 and W=11100100. After a high line level they are inverted.
- R6: From slot 4 on, the line level changes at the start of every slot, and it changes again in the middle of the slot only when the slot's bit is 1.
- R7: The channel-status bit in frame n of the block (sent in both subframes) is block bit n. Bit 1 is the non-audio flag. Bits 24 to 27 are rate code bits 0 to 3. All other bits are 0.
- R8: When a frame starts with the FIFO empty, both subframes carry zero samples with validity 1, and the underflow flag is set. The flag stays set until cleared through the status register.
- R9: While the run bit is 0, spdif_o is low and the frame state is held at its start. The first frame after run is set begins with preamble B.
- R10: A frame whose word came from the FIFO has validity 0 in both subframes, and it does not set the underflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| sample_valid_i | input | 1 | Sample word offered |
| sample_data_i | input | 32 | Right sample in 31:16, left sample in 15:0 |
| sample_ready_o | output | 1 | FIFO can take a word |
| spdif_o | output | 1 | Biphase-mark coded line output |

## Verification
The assertions check four properties on every cycle. The line holds its level between divider ticks, and ticks never fall on back-to-back cycles. The line sits low one cycle after the run bit drops. The underflow flag rises only after a frame pull from an empty FIFO, and it stays up until a clear. The frame content cannot be checked cycle by cycle, so it is left to the bench: preamble choice and polarity, slot order, channel-status bits spread across a whole block, and parity. The bench decodes the captured half-cells across a full block plus its wrap, under two divider settings, with a clamped divider, and with a FIFO that runs dry partway through.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int SUB_HALVES = 64;
  localparam logic [7:0] PAT_B = 8'b11101000;
  localparam logic [7:0] PAT_M = 8'b11100010;
  localparam logic [7:0] PAT_W = 8'b11100100;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} pre_sel_e;

  function automatic logic [7:0] pre_pattern(pre_sel_e sel);
    case (sel)
      PRE_B:   return PAT_B;
      PRE_M:   return PAT_M;
      default: return PAT_W;
    endcase
  endfunction
endpackage

// File: rtl/spdif_tx_clkdiv.sv
module spdif_tx_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // ratios below 2 clamp to 2
  assign lim    = (div_i < DIV_W'(2)) ? DIV_W'(1) : div_i - DIV_W'(1);
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q >= lim) cnt_q <= '0;
    else                   cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spdif_tx_fifo.sv
module spdif_tx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/spdif_tx_framer.sv
module spdif_tx_framer
  import spdif_tx_pkg::*;
#(
  parameter int FRAMES = 192
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        tick_i,
  input  logic        nonaudio_i,
  input  logic [3:0]  rate_i,
  input  logic        empty_i,
  input  logic [31:0] word_i,
  output logic        pull_o,
  output logic        spdif_o
);
  localparam int FW = $clog2(FRAMES);

  logic [5:0]    pos_q;
  logic          sub_q;
  logic [FW-1:0] frame_q;
  logic          line_q, pol_q;
  logic [15:0]   left_q, right_q;
  logic          vflag_q;

  logic [4:0]  slot;
  logic [4:0]  dslot;
  logic [15:0] samp;
  logic        cs_bit, par_bit, slot_bit, ref_lvl, next_line;
  logic [7:0]  pat;
  pre_sel_e    sel;

  assign slot    = pos_q[5:1];
  assign dslot   = slot - 5'd12;
  assign samp    = sub_q ? right_q : left_q;
  assign pull_o  = tick_i && (pos_q == '0) && !sub_q;
  assign spdif_o = line_q;

  always_comb begin
    cs_bit = 1'b0;
    if (frame_q == FW'(1))
      cs_bit = nonaudio_i;
    else if (frame_q >= FW'(24) && frame_q <= FW'(27))
      cs_bit = rate_i[frame_q[1:0]];
  end

  assign par_bit = ^{samp, vflag_q, cs_bit};

  always_comb begin
    if (slot < 5'd12)       slot_bit = 1'b0;
    else if (slot <= 5'd27) slot_bit = samp[dslot[3:0]];
    else begin
      case (slot[1:0])
        2'd0:    slot_bit = vflag_q;
        2'd1:    slot_bit = 1'b0;
        2'd2:    slot_bit = cs_bit;
        default: slot_bit = par_bit;
      endcase
    end
  end

  always_comb begin
    if (sub_q)                sel = PRE_W;
    else if (frame_q == '0)   sel = PRE_B;
    else                      sel = PRE_M;
    pat     = pre_pattern(sel);
    ref_lvl = (pos_q == '0) ? line_q : pol_q;
    if (slot < 5'd4)          next_line = pat[~pos_q[2:0]] ^ ref_lvl;
    else if (!pos_q[0])       next_line = ~line_q;
    else                      next_line = slot_bit ? ~line_q : line_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      sub_q   <= 1'b0;
      frame_q <= '0;
      line_q  <= 1'b0;
      pol_q   <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      vflag_q <= 1'b0;
    end else if (!run_i) begin
      pos_q   <= '0;
      sub_q   <= 1'b0;
      frame_q <= '0;
      line_q  <= 1'b0;
      pol_q   <= 1'b0;
    end else if (tick_i) begin
      if (pull_o) begin
        left_q  <= empty_i ? 16'h0 : word_i[15:0];
        right_q <= empty_i ? 16'h0 : word_i[31:16];
        vflag_q <= empty_i;
      end
      if (pos_q == '0) pol_q <= line_q;
      line_q <= next_line;
      pos_q  <= pos_q + 6'd1;
      if (pos_q == 6'(SUB_HALVES - 1)) begin
        sub_q <= ~sub_q;
        if (sub_q)
          frame_q <= (frame_q == FW'(FRAMES - 1)) ? '0 : frame_q + FW'(1);
      end
    end
  end
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int FRAMES     = 192
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        sample_valid_i,
  input  logic [31:0] sample_data_i,
  output logic        sample_ready_o,
  output logic        spdif_o
);
  localparam int DIV_RESET = CLK_HZ / (48000 * 128);

  logic             en_q, nonaudio_q, uf_q;
  logic [3:0]       rate_q;
  logic [DIV_W-1:0] div_q;
  logic             tick_w, pull_w, fifo_empty_w, fifo_full_w, uf_clr_w;
  logic [31:0]      fifo_word_w;
  logic             unused_wdata;

  assign unused_wdata   = ^{reg_wdata_i[31:8], reg_wdata_i[3:2]};
  assign sample_ready_o = !fifo_full_w;
  assign uf_clr_w       = reg_we_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      nonaudio_q <= 1'b0;
      rate_q     <= 4'b0010;
      div_q      <= DIV_W'(DIV_RESET);
      uf_q       <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == ADDR_CTRL) begin
        en_q       <= reg_wdata_i[0];
        nonaudio_q <= reg_wdata_i[1];
        rate_q     <= reg_wdata_i[7:4];
      end
      if (reg_we_i && reg_addr_i == ADDR_DIV)
        div_q <= reg_wdata_i[DIV_W-1:0];
      uf_q <= (uf_q && !uf_clr_w) || (pull_w && fifo_empty_w);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[0]   = en_q;
        reg_rdata_o[1]   = nonaudio_q;
        reg_rdata_o[7:4] = rate_q;
      end
      ADDR_DIV:  reg_rdata_o[DIV_W-1:0] = div_q;
      ADDR_STAT: begin
        reg_rdata_o[0] = uf_q;
        reg_rdata_o[1] = nonaudio_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  spdif_tx_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_q),
    .div_i  (div_q),
    .tick_o (tick_w)
  );

  spdif_tx_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (sample_valid_i),
    .data_i  (sample_data_i),
    .pop_i   (pull_w),
    .data_o  (fifo_word_w),
    .empty_o (fifo_empty_w),
    .full_o  (fifo_full_w)
  );

  spdif_tx_framer #(.FRAMES(FRAMES)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (en_q),
    .tick_i     (tick_w),
    .nonaudio_i (nonaudio_q),
    .rate_i     (rate_q),
    .empty_i    (fifo_empty_w),
    .word_i     (fifo_word_w),
    .pull_o     (pull_w),
    .spdif_o    (spdif_o)
  );
endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tick_i,
  input logic pull_i,
  input logic empty_i,
  input logic uf_i,
  input logic uf_clr_i,
  input logic spdif_i
);
  // R1: line only moves on a divider tick
  assert_line_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i |=> $stable(spdif_i));

  // R1: divider ratio never below 2
  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  assert_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !spdif_i);

  assert_uf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i && !uf_clr_i |=> uf_i);

  assert_uf_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uf_i) |-> $past(pull_i && empty_i));
endmodule

bind spdif_tx spdif_tx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_q),
  .tick_i   (tick_w),
  .pull_i   (pull_w),
  .empty_i  (fifo_empty_w),
  .uf_i     (uf_q),
  .uf_clr_i (uf_clr_w),
  .spdif_i  (spdif_o)
);

// File: tb/spdif_tx_tb_top.sv
module spdif_tx_tb_top;
  localparam logic [7:0] EB = 8'b11101000;
  localparam logic [7:0] EM = 8'b11100010;
  localparam logic [7:0] EW = 8'b11100100;
  localparam int MAXC = 193 * 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        svalid = 1'b0;
  logic [31:0] sdata = '0;
  logic        sready;
  logic        spdif;

  int errors = 0;
  int checks = 0;
  int push_n = 0;
  int feed_lim = 0;
  logic cells [MAXC];

  always #2 clk = ~clk;

  spdif_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sample_valid_i(svalid),
    .sample_data_i(sdata), .sample_ready_o(sready), .spdif_o(spdif)
  );

  function automatic logic [31:0] gen(int k);
    logic [15:0] l, r;
    l = 16'(k * 40503 + 7);
    r = 16'((k * 9973) ^ 23205);
    return {r, l};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) push_n <= 0;
    else if (svalid && sready) push_n <= push_n + 1;
  end

  always @(negedge clk) begin
    svalid <= rst_n && (push_n < feed_lim);
    sdata  <= gen(push_n);
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic do_reset();
    feed_lim = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // capture half-cells, aligned on the first rising edge after run
  task automatic capture(int d, int nfr);
    @(negedge clk);
    while (spdif !== 1'b1) @(negedge clk);
    for (int k = 0; k < nfr * 128; k++) begin
      cells[k] = spdif;
      repeat (d) @(negedge clk);
    end
  endtask

  task automatic decode(int nfr, bit na, logic [3:0] rate, int good_frames);
    for (int f = 0; f < nfr; f++) begin
      for (int s = 0; s < 2; s++) begin
        int base, fb, terr;
        logic prev, lvl, a, b, cs_exp;
        logic [7:0] got, exp_pat;
        logic [27:0] bits;
        logic [15:0] exp_s;
        logic [31:0] w;
        base = (f * 2 + s) * 64;
        fb = f % 192;
        prev = (base == 0) ? 1'b0 : cells[base-1];
        for (int h = 0; h < 8; h++) got[7-h] = cells[base+h];
        exp_pat = (s == 1) ? EW : ((fb == 0) ? EB : EM);
        exp_pat = exp_pat ^ {8{prev}};
        chk(got == exp_pat, "R5 preamble", 32'(got), 32'(exp_pat));
        terr = 0;
        lvl = cells[base+7];
        for (int sl = 4; sl < 32; sl++) begin
          a = cells[base+2*sl];
          b = cells[base+2*sl+1];
          if (a == lvl) terr++;
          bits[sl-4] = (a != b);
          lvl = b;
        end
        chk(terr == 0, "R6 slot-edge", 32'(terr), 32'd0);
        w = gen(f);
        exp_s = (f < good_frames) ? ((s == 1) ? w[31:16] : w[15:0]) : 16'h0;
        chk(bits[7:0] == 8'h0, "R4 pad", 32'(bits[7:0]), 32'd0);
        if (f < good_frames) begin
          chk(bits[23:8] == exp_s, "R3 sample", 32'(bits[23:8]), 32'(exp_s));
          chk(bits[24] == 1'b0, "R10 validity", 32'(bits[24]), 32'd0);
        end else begin
          chk(bits[23:8] == 16'h0, "R8 silence", 32'(bits[23:8]), 32'd0);
          chk(bits[24] == 1'b1, "R8 validity", 32'(bits[24]), 32'd1);
        end
        chk(bits[25] == 1'b0, "R4 user", 32'(bits[25]), 32'd0);
        cs_exp = 1'b0;
        if (fb == 1) cs_exp = na;
        else if (fb >= 24 && fb <= 27) cs_exp = rate[fb-24];
        chk(bits[26] == cs_exp, "R7 chstat", 32'(bits[26]), 32'(cs_exp));
        chk(^bits == 1'b0, "R4 parity", 32'(^bits), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // reset state
    chk(spdif == 1'b0, "R9 reset line", 32'(spdif), 32'd0);
    chk(sready == 1'b1, "R3 reset ready", 32'(sready), 32'd1);
    rd_chk(2'd0, 32'h20, "R2 ctrl reset");
    rd_chk(2'd1, 32'd16, "R2 div reset");
    rd_chk(2'd2, 32'h0, "R2 stat reset");

    // disabled: line stays low, FIFO fills
    feed_lim = 1000000;
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (spdif) hi++;
      end
      chk(hi == 0, "R9 idle low", 32'(hi), 32'd0);
    end
    chk(sready == 1'b0, "R3 full ready", 32'(sready), 32'd0);

    // full block plus wrap, divider 2, audio
    wr(2'd1, 32'd2);
    rd_chk(2'd1, 32'd2, "R2 div write");
    wr(2'd0, 32'h21);
    capture(2, 193);
    decode(193, 1'b0, 4'b0010, 193);
    wr(2'd0, 32'h20);
    rd_chk(2'd2, 32'h0, "R10 no underflow");

    // divider 3, non-audio, other rate code
    do_reset();
    feed_lim = 1000000;
    wr(2'd1, 32'd3);
    wr(2'd0, 32'hC3);
    rd_chk(2'd0, 32'hC3, "R2 ctrl write");
    rd_chk(2'd2, 32'h2, "R2 stat nonaudio");
    capture(3, 30);
    decode(30, 1'b1, 4'b1100, 30);

    // divider 1 clamps to 2
    do_reset();
    feed_lim = 1000000;
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h01);
    capture(2, 3);
    decode(3, 1'b0, 4'b0000, 3);

    // FIFO runs dry after two words
    do_reset();
    feed_lim = 2;
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h21);
    capture(2, 4);
    decode(4, 1'b0, 4'b0010, 2);
    wr(2'd0, 32'h20);
    rd_chk(2'd2, 32'h1, "R8 sticky set");
    repeat (20) @(negedge clk);
    rd_chk(2'd2, 32'h1, "R8 sticky held");
    wr(2'd2, 32'h1);
    rd_chk(2'd2, 32'h0, "R8 cleared");
    chk(spdif == 1'b0, "R9 low after stop", 32'(spdif), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule